// File: doc/BRIEF.md
# Phase-Accumulator Multi-Waveform Generator

This block feeds a DAC path with one 8-bit unsigned sample for every update strobe. It holds a 16-bit phase accumulator. The upper 7 bits address a 128-step waveform cycle and the lower 9 bits hold a fraction. Each strobe adds a programmable step to the accumulator. The output frequency is therefore set by the step size, while the sample rate stays at the fixed strobe rate of the DAC path. A step of 512 gives one full cycle every 128 updates. The step may have a fractional part, and only the integer part picks the table position. There is no interpolation between table positions.

A mode input selects one of four shapes: sine, ramp, triangle or square. The sine shape comes from a 32-entry quarter-cycle table, which is mirrored and inverted to cover the other three quarters. An amplitude input scales every shape around mid-scale, and the result is clamped to the 8-bit code range.

The strobe works as a one-cycle request, and the output works as a one-cycle valid pulse. There is no back-pressure. The sink must take the sample in the cycle its valid pulse is high. The sample stays on the output until the next strobe.

Top module: `wg_top`

## Requirements
- R1: While reset is active, and at the first clock after it, `smp_o` is 128 and `smp_vld_o` is 0.
- R2: The accumulator adds `step_i` modulo 2^16 once for each clock where `upd_i` is high. On clocks where `upd_i` is low, the accumulator keeps its value.
- R3: `smp_vld_o` is high for exactly the one clock after each clock with `upd_i` high. At that same point `smp_o` takes the new sample. `smp_o` does not change after a clock where `upd_i` was low.
- R4: A sample is computed from the accumulator value as it was before that strobe's addition. The table index is accumulator bits [15:9]. The first sample after reset uses index 0.
- R5: Mode 1 (ramp) gives the raw value {idx, idx[6]}, which covers 0 to 255.
- R6: Mode 2 (triangle) uses t = idx[5:0] when idx < 64 and t = 63 - idx[5:0] otherwise. The raw value is {t, t[5:4]}.
- R7: Mode 3 (square) gives a raw value of 255 for idx < 64 and 0 otherwise.
- R8: Mode 0 (sine) gives a raw value of 131 at idx 0 and 255 at idx 31 and 32. For i < 32 it satisfies raw(63-i) = raw(i) and raw(64+i) = 256 - raw(i). It does not fall anywhere in idx 0 to 31.
- R9: The output is 128 + floor((raw - 128) * amp_i / 256), clamped to 0..255. An `amp_i` of 256 leaves the raw value unchanged, and 0 gives 128.
- R10: The step size sets the period. With a step of 1024, the samples repeat every 64 updates. With a step of 256, the index advances once every two updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Sample-update strobe |
| step_i | input | 16 | Phase step: 7 integer bits and 9 fraction bits |
| mode_i | input | 2 | Shape: 0 sine, 1 ramp, 2 triangle, 3 square |
| amp_i | input | 9 | Amplitude; 256 is unity |
| smp_o | output | 8 | Unsigned output sample |
| smp_vld_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
A wrong accumulator value shows up at the very next strobe, as a sample taken from the wrong table position. The bench keeps its own phase model and compares every sample against it. A slip in the sine folding appears as a broken mirror or inversion between quarters within one 128-update cycle. Samples taken at full scale expose it there. A stray accumulator step without a strobe shifts every later sample, and the per-strobe comparison catches it one strobe later.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int WG_IDX_W = 7;
  localparam int WG_SMP_W = 8;

  typedef enum logic [1:0] {
    WG_SINE   = 2'd0,
    WG_RAMP   = 2'd1,
    WG_TRI    = 2'd2,
    WG_SQUARE = 2'd3
  } wg_mode_e;

  // quarter-cycle sine magnitude, sampled at half-step offsets, peak 127
  function automatic logic [6:0] wg_qsine(input logic [4:0] k);
    logic [6:0] v;
    case (k)
      5'd0:  v = 7'd3;   5'd1:  v = 7'd9;   5'd2:  v = 7'd16;  5'd3:  v = 7'd22;
      5'd4:  v = 7'd28;  5'd5:  v = 7'd34;  5'd6:  v = 7'd40;  5'd7:  v = 7'd46;
      5'd8:  v = 7'd51;  5'd9:  v = 7'd57;  5'd10: v = 7'd63;  5'd11: v = 7'd68;
      5'd12: v = 7'd73;  5'd13: v = 7'd78;  5'd14: v = 7'd83;  5'd15: v = 7'd88;
      5'd16: v = 7'd92;  5'd17: v = 7'd96;  5'd18: v = 7'd100; 5'd19: v = 7'd104;
      5'd20: v = 7'd107; 5'd21: v = 7'd111; 5'd22: v = 7'd113; 5'd23: v = 7'd116;
      5'd24: v = 7'd118; 5'd25: v = 7'd121; 5'd26: v = 7'd122; 5'd27: v = 7'd124;
      5'd28: v = 7'd125; 5'd29: v = 7'd126; 5'd30: v = 7'd127; default: v = 7'd127;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/wg_phase_acc.sv
module wg_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] phase_o
);
  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= '0;
    else if (adv_i) phase_q <= phase_q + step_i;
  end

  assign phase_o = phase_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(phase_q)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> phase_q == ACC_W'($past(phase_q) + $past(step_i))); // R2
endmodule

// File: rtl/wg_shape.sv
module wg_shape
  import wg_pkg::*;
(
  input  wg_mode_e              mode_i,
  input  logic [WG_IDX_W-1:0]   idx_i,
  output logic [WG_SMP_W-1:0]   raw_o
);
  localparam int HALF_W = WG_IDX_W - 1;
  localparam int QTR_W  = WG_IDX_W - 2;

  logic [HALF_W-1:0] tri_t;
  logic [QTR_W-1:0]  qaddr;
  logic [6:0]        qmag;

  always_comb begin
    tri_t = idx_i[WG_IDX_W-1] ? ~idx_i[HALF_W-1:0] : idx_i[HALF_W-1:0];
    qaddr = idx_i[HALF_W-1] ? ~idx_i[QTR_W-1:0] : idx_i[QTR_W-1:0];
    qmag  = wg_qsine(qaddr);
    unique case (mode_i)
      WG_RAMP:   raw_o = {idx_i, idx_i[WG_IDX_W-1]};
      WG_TRI:    raw_o = {tri_t, tri_t[HALF_W-1 -: 2]};
      WG_SQUARE: raw_o = idx_i[WG_IDX_W-1] ? '0 : '1;
      default:   raw_o = idx_i[WG_IDX_W-1] ? (8'd128 - {1'b0, qmag})
                                           : (8'd128 + {1'b0, qmag});
    endcase
  end
endmodule

// File: rtl/wg_scale.sv
module wg_scale #(
  parameter int SMP_W = 8,
  parameter int AMP_W = 9
) (
  input  logic [SMP_W-1:0] raw_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [SMP_W-1:0] out_o
);
  localparam int PW   = SMP_W + AMP_W + 2;
  localparam int MID  = 1 << (SMP_W - 1);
  localparam int MAXV = (1 << SMP_W) - 1;

  logic signed [PW-1:0] ctr, gain, prod, sum;

  always_comb begin
    ctr  = $signed(PW'(raw_i)) - $signed(PW'(MID));
    gain = $signed(PW'(amp_i));
    prod = ctr * gain;
    sum  = (prod >>> SMP_W) + $signed(PW'(MID));
    if (sum < 0)                        out_o = '0;
    else if (sum > $signed(PW'(MAXV)))  out_o = '1;
    else                                out_o = sum[SMP_W-1:0];
  end
endmodule

// File: rtl/wg_top.sv
module wg_top
  import wg_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int AMP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [1:0]       mode_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [7:0]       smp_o,
  output logic             smp_vld_o
);
  localparam int MID = 1 << (WG_SMP_W - 1);

  logic [ACC_W-1:0]    phase;
  logic [WG_IDX_W-1:0] idx;
  logic [WG_SMP_W-1:0] raw, scaled, smp_q;
  logic                vld_q;

  wg_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .adv_i(upd_i), .step_i(step_i), .phase_o(phase)
  );

  assign idx = phase[ACC_W-1 -: WG_IDX_W];

  wg_shape shape_i (
    .mode_i(wg_mode_e'(mode_i)), .idx_i(idx), .raw_o(raw)
  );

  wg_scale #(.SMP_W(WG_SMP_W), .AMP_W(AMP_W)) scale_i (
    .raw_i(raw), .amp_i(amp_i), .out_o(scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= WG_SMP_W'(MID);
      vld_q <= 1'b0;
    end else begin
      vld_q <= upd_i;
      if (upd_i) smp_q <= scaled;
    end
  end

  assign smp_o     = smp_q;
  assign smp_vld_o = vld_q;

  AST_VLD_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> smp_vld_o); // R3
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> !smp_vld_o); // R3
  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(smp_o)); // R3
  AST_SINE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && mode_i == 2'd0 && amp_i == AMP_W'(256)) |=> (smp_o[7] != $past(phase[ACC_W-1]))); // R8
  AST_ZERO_AMP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && amp_i == '0) |=> smp_o == 8'd128); // R9
endmodule

// File: tb/wg_top_tb_top.sv
module wg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_i = 1'b0;
  logic [15:0] step_i = '0;
  logic [1:0]  mode_i = '0;
  logic [8:0]  amp_i = 9'd256;
  logic [7:0]  smp_o;
  logic        smp_vld_o;

  int n_chk = 0;
  int n_fail = 0;
  int bphase = 0;
  int cyc = 0;
  int sine_buf [128];

  always #4 clk = ~clk;

  wg_top dut_i (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .step_i(step_i),
    .mode_i(mode_i), .amp_i(amp_i), .smp_o(smp_o), .smp_vld_o(smp_vld_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int raw_of(int mode, int idx);
    int t;
    case (mode)
      1: return idx * 2 + (idx >> 6);
      2: begin t = (idx < 64) ? idx : 127 - idx; return t * 4 + (t >> 4); end
      3: return (idx < 64) ? 255 : 0;
      default: return -1;
    endcase
  endfunction

  function automatic int scale_of(int raw, int amp);
    int p;
    p = ((raw - 128) * amp) >>> 8;
    p = p + 128;
    if (p < 0) p = 0;
    if (p > 255) p = 255;
    return p;
  endfunction

  // one strobe; returns the sample seen one clock later
  task automatic strobe(output int got);
    @(negedge clk) upd_i = 1'b1;
    @(negedge clk) upd_i = 1'b0;
    got = smp_o;
    chk("R3 valid after strobe", smp_vld_o, 1);
  endtask

  task automatic run_model(string req, int mode, int step, int amp, int count);
    int got, idx;
    mode_i = 2'(mode); step_i = 16'(step); amp_i = 9'(amp);
    for (int i = 0; i < count; i++) begin
      idx = (bphase >> 9) & 127;
      strobe(got);
      chk(req, got, scale_of(raw_of(mode, idx), amp));
      bphase = (bphase + step) & 16'hFFFF;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 sample in reset", smp_o, 128);
    chk("R1 valid in reset", smp_vld_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sample after reset", smp_o, 128);
    chk("R1 valid after reset", smp_vld_o, 0);
  endtask

  task automatic t_first_and_hold();
    int got, held;
    // R4: first sample uses index 0
    mode_i = 2'd3; step_i = 16'd512; amp_i = 9'd256;
    strobe(got);
    chk("R4 first sample index 0", got, 255);
    bphase = 512;
    held = smp_o;
    repeat (5) begin
      @(negedge clk);
      chk("R3 no valid without strobe", smp_vld_o, 0);
      chk("R3 sample held", smp_o, held);
    end
    // R2: idle cycles must not advance phase
    run_model("R2 idle keeps phase", 1, 512, 256, 3);
  endtask

  task automatic t_shapes();
    run_model("R5 ramp", 1, 512, 256, 130);
    run_model("R6 triangle", 2, 768, 256, 100);
    run_model("R7 square", 3, 1536, 256, 40);
  endtask

  task automatic t_wrap();
    run_model("R2 wrap modulo 2^16", 1, 16'hC000, 256, 6);
    run_model("R2 odd step", 2, 16'hFFFF, 256, 5);
  endtask

  task automatic t_freq();
    int first [64];
    int got;
    bphase = bphase & 16'hFFFF;
    for (int i = 0; i < 64; i++) begin
      mode_i = 2'd1; step_i = 16'd1024; amp_i = 9'd256;
      strobe(got); first[i] = got;
    end
    for (int i = 0; i < 64; i++) begin
      strobe(got);
      chk("R10 period of 64 updates at step 1024", got, first[i]);
    end
    bphase = (bphase + 128 * 1024) & 16'hFFFF;
    run_model("R10 fractional step 256", 1, 256, 256, 20);
  endtask

  task automatic t_sine();
    int got;
    // bring phase to zero: run ramp until it wraps
    run_model("R5 ramp align", 1, (65536 - bphase) & 16'hFFFF, 256, 1);
    mode_i = 2'd0; step_i = 16'd512; amp_i = 9'd256;
    for (int i = 0; i < 128; i++) begin strobe(got); sine_buf[i] = got; end
    bphase = 0;
    chk("R8 sine start", sine_buf[0], 131);
    chk("R8 sine peak 31", sine_buf[31], 255);
    chk("R8 sine peak 32", sine_buf[32], 255);
    for (int i = 0; i < 32; i++) begin
      chk("R8 sine mirror", sine_buf[63 - i], sine_buf[i]);
      chk("R8 sine invert", sine_buf[64 + i], 256 - sine_buf[i]);
      if (i < 31) chk("R8 sine rising", int'(sine_buf[i + 1] >= sine_buf[i]), 1);
    end
  endtask

  task automatic t_amp();
    run_model("R9 half amplitude ramp", 1, 512, 128, 128);
    run_model("R9 zero amplitude", 3, 4096, 0, 16);
    run_model("R9 saturating gain", 1, 512, 511, 128);
    run_model("R9 square gain 384", 3, 2048, 384, 64);
  endtask

  initial begin
    t_reset();
    t_first_and_hold();
    t_shapes();
    t_wrap();
    t_freq();
    t_sine();
    t_amp();
    summary();
  end
endmodule